// File: doc/BRIEF.md
# Vectoring Interrupt Controller

The block collects up to 64 interrupt lines and gives a CPU one request line and a vector register. The vector register names the source to service next. Each source has its own configuration word. The word picks edge or level sensing and sets a priority level.

Masks live in two 32-bit banks: sources 0..31 in the low bank and 32..63 in the high bank. Masks are never written directly. Software writes a set-strobe register to enable sources and a clear-strobe register to disable them.

A global-enable bit gates the request line. An end-of-interrupt write retires the edge latch of the source being vectored. A soft-reset write clears all state. A bind port fills a 64-entry table of single bits, which is brought out as a vector for an external vectored controller.

The register bus is plain strobes, with no flow control. A write takes effect at the clock edge where `bus_wr` is high. Read data is registered: `bus_rdata` holds the selected word from the edge after `bus_rd` until the next read. No interface here carries streaming data, so no valid/ready back-pressure applies.

Top module: `irqc_top`

## Requirements
- R1: Writing word 0x400 sets mask bit n for each 1 in data bit n (n = 0..31). Word 0x404 does the same for source 32+n. Words 0x408 and 0x40C clear mask bits in the same positions. Data bits written as 0 leave their mask bits unchanged. All masks reset to disabled.
- R2: A source whose configuration edge bit (bit 0) is 0 is level sensitive. It is active exactly while its input is high and its mask bit is set.
- R3: A source with edge bit 1 latches a 0-to-1 transition of its input into a pending flag. The latch works even while the source is masked. The flag stays set after the input falls. It counts as active only while the mask bit is set. A held-high input does not set the flag again.
- R4: An edge source's pending flag clears when its configuration word is written. It also clears when a write to word 0x410 (end of interrupt) occurs while the vector names that source. That write leaves the flags of all other sources untouched.
- R5: A read of word 0x414 returns the active source with the largest level. Ties go to the lowest source number. With no active source it returns 64, which marks the read as spurious.
- R6: `irq` is high exactly when bit 0 of word 0x41C (global enable) is 1 and at least one source is active. The vector does not depend on the global enable.
- R7: Writing word 0x418 with data bit 0 set clears every configuration, mask, pending flag, bind entry and the global enable. A write with bit 0 clear changes nothing.
- R8: Source n's configuration word is at byte offset 8*n. It holds the edge bit in bit 0 and the level in bits 7:4. It reads back with all other bits 0.
- R9: Writing word 0x420 stores data bit 0 into `bind_tbl[k]`, where k is data bits 21:16.
- R10: A read returns data on `bus_rdata` one cycle after `bus_rd`. The strobe words 0x400-0x410, 0x418 and 0x420 read as 0, as do unaligned addresses.
- R11: An asserted `rst_n` (low) clears all state at once, so `irq` and `bind_tbl` go to 0 without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 64 | Interrupt source lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 18 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the CPU |
| bind_tbl | output | 64 | Bind table for the external vectored mode |

## Verification
A stuck or lost edge latch shows at the ports on the next vector read. Such a read returns either the stale source or 64, and `irq` disagrees in the same cycle. A wrong mask bit shows up in the mask sweep, which holds every input high, so the vector moves to the wrong source one cycle after the strobe write. A priority comparison that is off by one flips tie or level ordering. The patterned input sweeps catch that on the read that directly follows the input change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W       = 32;
  // control word byte offsets (above the per-source configuration space)
  localparam int OFS_EN_LO    = 'h400;
  localparam int OFS_EN_HI    = 'h404;
  localparam int OFS_DIS_LO   = 'h408;
  localparam int OFS_DIS_HI   = 'h40C;
  localparam int OFS_EOI      = 'h410;
  localparam int OFS_VEC      = 'h414;
  localparam int OFS_RST      = 'h418;
  localparam int OFS_GEN      = 'h41C;
  localparam int OFS_BIND     = 'h420;
  // field positions
  localparam int CFG_EDGE_BIT = 0;
  localparam int CFG_LVL_LSB  = 4;
  localparam int BIND_IDX_LSB = 16;
  localparam int BANK_W       = 32;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_EN_LO, SEL_EN_HI, SEL_DIS_LO, SEL_DIS_HI,
    SEL_EOI, SEL_VEC, SEL_RST, SEL_GEN, SEL_BIND
  } reg_sel_e;
endpackage

// File: rtl/irqc_src.sv
module irqc_src #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             src_in,
  input  logic             cfg_we,
  input  logic             cfg_edge_in,
  input  logic [LVL_W-1:0] cfg_lvl_in,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             eoi_hit,
  input  logic             bind_we,
  input  logic             bind_val,
  output logic             cfg_edge,
  output logic [LVL_W-1:0] cfg_lvl,
  output logic             active,
  output logic             bind_bit
);
  logic mask_q, pend_q, prev_q;
  logic rise;

  assign rise = src_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_edge <= 1'b0;
      cfg_lvl  <= '0;
      mask_q   <= 1'b0;
      pend_q   <= 1'b0;
      prev_q   <= 1'b0;
      bind_bit <= 1'b0;
    end else if (soft_clr) begin
      cfg_edge <= 1'b0;
      cfg_lvl  <= '0;
      mask_q   <= 1'b0;
      pend_q   <= 1'b0;
      prev_q   <= 1'b0;
      bind_bit <= 1'b0;
    end else begin
      prev_q <= src_in;
      if (cfg_we) begin
        cfg_edge <= cfg_edge_in;
        cfg_lvl  <= cfg_lvl_in;
      end
      if (en_clr)      mask_q <= 1'b0;
      else if (en_set) mask_q <= 1'b1;
      if (rise && cfg_edge)       pend_q <= 1'b1;
      else if (cfg_we || eoi_hit) pend_q <= 1'b0;
      if (bind_we) bind_bit <= bind_val;
    end
  end

  assign active = mask_q & (cfg_edge ? pend_q : src_in);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NSRC  = 64,
  parameter int LVL_W = 4,
  parameter int VEC_W = 7
) (
  input  logic [NSRC-1:0]  active,
  input  logic [LVL_W-1:0] lvl [NSRC],
  output logic [VEC_W-1:0] vec,
  output logic             any
);
  logic             found;
  logic [LVL_W-1:0] best;

  // linear scan: a strictly larger level displaces the holder, so ties keep the lowest index
  always_comb begin
    found = 1'b0;
    best  = '0;
    vec   = VEC_W'(NSRC);
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!found || lvl[i] > best)) begin
        found = 1'b1;
        best  = lvl[i];
        vec   = VEC_W'(i);
      end
    end
  end

  assign any = |active;
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 18,
  parameter int VEC_W  = 7,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   cfg_edge,
  input  logic [LVL_W-1:0]  cfg_lvl [NSRC],
  input  logic [VEC_W-1:0]  vec,
  output logic [NSRC-1:0]   cfg_we,
  output logic [NSRC-1:0]   en_set,
  output logic [NSRC-1:0]   en_clr,
  output logic              eoi_we,
  output logic              soft_clr,
  output logic              bind_we,
  output logic [IDX_W-1:0]  bind_idx,
  output logic              bind_val,
  output logic              genable,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CFG_SPAN = NSRC * 8;

  reg_sel_e          sel;
  logic [IDX_W-1:0]  cfg_idx;
  logic [DATA_W-1:0] rd_word;
  logic              gen_q;

  always_comb begin
    sel     = SEL_NONE;
    cfg_idx = bus_addr[IDX_W+2:3];
    if (bus_addr < ADDR_W'(CFG_SPAN)) begin
      if (bus_addr[2:0] == 3'b000) sel = SEL_CFG;
    end
    else if (bus_addr == ADDR_W'(OFS_EN_LO))  sel = SEL_EN_LO;
    else if (bus_addr == ADDR_W'(OFS_EN_HI))  sel = SEL_EN_HI;
    else if (bus_addr == ADDR_W'(OFS_DIS_LO)) sel = SEL_DIS_LO;
    else if (bus_addr == ADDR_W'(OFS_DIS_HI)) sel = SEL_DIS_HI;
    else if (bus_addr == ADDR_W'(OFS_EOI))    sel = SEL_EOI;
    else if (bus_addr == ADDR_W'(OFS_VEC))    sel = SEL_VEC;
    else if (bus_addr == ADDR_W'(OFS_RST))    sel = SEL_RST;
    else if (bus_addr == ADDR_W'(OFS_GEN))    sel = SEL_GEN;
    else if (bus_addr == ADDR_W'(OFS_BIND))   sel = SEL_BIND;
  end

  // per-source strobes; the bank a source belongs to picks its strobe words
  for (genvar i = 0; i < NSRC; i++) begin : g_strb
    assign cfg_we[i] = bus_wr && (sel == SEL_CFG) && (cfg_idx == IDX_W'(i));
    if (i < BANK_W) begin : g_lo
      assign en_set[i] = bus_wr && (sel == SEL_EN_LO)  && bus_wdata[i];
      assign en_clr[i] = bus_wr && (sel == SEL_DIS_LO) && bus_wdata[i];
    end else begin : g_hi
      assign en_set[i] = bus_wr && (sel == SEL_EN_HI)  && bus_wdata[i-BANK_W];
      assign en_clr[i] = bus_wr && (sel == SEL_DIS_HI) && bus_wdata[i-BANK_W];
    end
  end

  assign eoi_we   = bus_wr && (sel == SEL_EOI);
  assign soft_clr = bus_wr && (sel == SEL_RST) && bus_wdata[0];
  assign bind_we  = bus_wr && (sel == SEL_BIND);
  assign bind_idx = bus_wdata[BIND_IDX_LSB +: IDX_W];
  assign bind_val = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            gen_q <= 1'b0;
    else if (soft_clr)                     gen_q <= 1'b0;
    else if (bus_wr && (sel == SEL_GEN))   gen_q <= bus_wdata[0];
  end
  assign genable = gen_q;

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_CFG: begin
        rd_word[CFG_EDGE_BIT]              = cfg_edge[cfg_idx];
        rd_word[CFG_LVL_LSB +: LVL_W]      = cfg_lvl[cfg_idx];
      end
      SEL_VEC: rd_word[VEC_W-1:0]          = vec;
      SEL_GEN: rd_word[0]                  = gen_q;
      default: rd_word                     = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 18,
  localparam int VEC_W = $clog2(NSRC + 1),
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [NSRC-1:0]   bind_tbl
);
  logic [NSRC-1:0]  cfg_we, en_set, en_clr, cfg_edge, active;
  logic [LVL_W-1:0] cfg_lvl [NSRC];
  logic [VEC_W-1:0] vec;
  logic             any, eoi_we, soft_clr, bind_we, bind_val, genable;
  logic [IDX_W-1:0] bind_idx;

  irqc_regif #(
    .NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cfg_edge  (cfg_edge),
    .cfg_lvl   (cfg_lvl),
    .vec       (vec),
    .cfg_we    (cfg_we),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .eoi_we    (eoi_we),
    .soft_clr  (soft_clr),
    .bind_we   (bind_we),
    .bind_idx  (bind_idx),
    .bind_val  (bind_val),
    .genable   (genable),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqc_src #(.LVL_W(LVL_W)) u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_clr    (soft_clr),
      .src_in      (src_in[i]),
      .cfg_we      (cfg_we[i]),
      .cfg_edge_in (bus_wdata[CFG_EDGE_BIT]),
      .cfg_lvl_in  (bus_wdata[CFG_LVL_LSB +: LVL_W]),
      .en_set      (en_set[i]),
      .en_clr      (en_clr[i]),
      .eoi_hit     (eoi_we && (vec == VEC_W'(i))),
      .bind_we     (bind_we && (bind_idx == IDX_W'(i))),
      .bind_val    (bind_val),
      .cfg_edge    (cfg_edge[i]),
      .cfg_lvl     (cfg_lvl[i]),
      .active      (active[i]),
      .bind_bit    (bind_tbl[i])
    );
  end

  irqc_prio #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_prio (
    .active (active),
    .lvl    (cfg_lvl),
    .vec    (vec),
    .any    (any)
  );

  assign irq = genable & any;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 18,
  parameter int VEC_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [5:0]        wd_idx,
  input logic              wd_bit0,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [VEC_W-1:0]  vec,
  input logic [NSRC-1:0]   bind_tbl
);
  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec < VEC_W'(NSRC)));                                        // R6
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec <= VEC_W'(NSRC));                                                 // R5
  AST_DISABLE_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h408) && wd_bit0) |=> (vec != '0));   // R1
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h418) && wd_bit0) |=> (!irq && bind_tbl == '0)); // R7
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h400)) |=> (bus_rdata == '0));       // R10
  AST_BIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h420) && int'(wd_idx) < NSRC)
      |=> (bind_tbl[$past(wd_idx)] == $past(wd_bit0)));                   // R9
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .wd_idx    (bus_wdata[21:16]),
  .wd_bit0   (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .vec       (vec),
  .bind_tbl  (bind_tbl)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int A_EN_LO = 'h400, A_EN_HI = 'h404, A_DIS_LO = 'h408, A_DIS_HI = 'h40C;
  localparam int A_EOI = 'h410, A_VEC = 'h414, A_RST = 'h418, A_GEN = 'h41C, A_BIND = 'h420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [63:0] bind_tbl;

  int checks = 0, fails = 0;
  logic [63:0] mask_m = '0;
  logic [63:0] xs = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .bind_tbl(bind_tbl)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = a[17:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = a[17:0]; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); src_in = v;
    @(negedge clk);
  endtask

  function automatic int lvl_of(input int n);
    return (n * 5 + 3) % 16;
  endfunction

  function automatic int exp_vec(input logic [63:0] act);
    int w = 64;
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (act[i] && lvl_of(i) > best) begin best = lvl_of(i); w = i; end
    return w;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] x);
    logic [63:0] y = x;
    y ^= y << 13; y ^= y >> 7; y ^= y << 17;
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R11: asynchronous reset state
    chk(irq == 1'b0, "R11 irq after reset", irq, 0);
    chk(bind_tbl == '0, "R11 bind after reset", bind_tbl, 0);
    @(negedge clk); rst_n = 1'b1;
    brd(A_VEC, d); chk(d == 64, "R5 idle vector", d, 64);
    brd(8 * 5, d);  chk(d == 0, "R8 cfg reset value", d, 0);

    // R8: configuration readback sweep
    for (int n = 0; n < 64; n++) begin
      w = 32'(n) * 32'h9E37_79B1;
      bwr(8 * n, w);
      brd(8 * n, d);
      chk(d == (w & 32'hF1), "R8 cfg readback", d, w & 32'hF1);
    end
    brd(8 * 7 + 4, d); chk(d == 0, "R10 unaligned read", d, 0);

    // level configuration for all sources, everything unmasked, global enable on
    for (int n = 0; n < 64; n++) bwr(8 * n, 32'(lvl_of(n)) << 4);
    bwr(A_EN_LO, 32'hFFFF_FFFF); bwr(A_EN_HI, 32'hFFFF_FFFF); mask_m = '1;
    bwr(A_GEN, 1);

    // R2 / R5 / R6: one source at a time
    for (int n = 0; n < 64; n++) begin
      set_src(64'd1 << n);
      chk(irq == 1'b1, "R6 irq with one level source", irq, 1);
      brd(A_VEC, d); chk(d == 32'(n), "R2 single level source vector", d, n);
    end
    set_src('0);
    chk(irq == 1'b0, "R2 level input low", irq, 0);

    // R5: patterned inputs, highest level wins, ties lowest
    for (int k = 0; k < 24; k++) begin
      xs = nxt(xs);
      set_src(xs);
      brd(A_VEC, d); chk(d == 32'(exp_vec(xs)), "R5 priority pattern", d, exp_vec(xs));
    end
    set_src('1);
    brd(A_VEC, d); chk(d == 32'(exp_vec('1)), "R5 all sources", d, exp_vec('1));

    // R1: mask banks, set/clear strobes, zeros leave bits alone
    bwr(A_DIS_LO, 32'hFFFF_FFFF); bwr(A_DIS_HI, 32'hFFFF_FFFF); mask_m = '0;
    brd(A_VEC, d); chk(d == 64, "R1 all masked", d, 64);
    chk(irq == 1'b0, "R1 all masked irq", irq, 0);
    for (int k = 0; k < 48; k++) begin
      xs = nxt(xs);
      w = xs[63:32];
      case (xs[1:0])
        2'd0: begin bwr(A_EN_LO,  w); mask_m[31:0]  = mask_m[31:0]  |  w; end
        2'd1: begin bwr(A_EN_HI,  w); mask_m[63:32] = mask_m[63:32] |  w; end
        2'd2: begin bwr(A_DIS_LO, w); mask_m[31:0]  = mask_m[31:0]  & ~w; end
        default: begin bwr(A_DIS_HI, w); mask_m[63:32] = mask_m[63:32] & ~w; end
      endcase
      brd(A_VEC, d); chk(d == 32'(exp_vec(mask_m)), "R1 mask bank update", d, exp_vec(mask_m));
      chk(irq == (mask_m != '0), "R1 irq follows mask", irq, mask_m != '0);
    end

    // R3 / R4: edge source 40 (high bank bit 8)
    set_src('0);
    bwr(A_DIS_LO, 32'hFFFF_FFFF); bwr(A_DIS_HI, 32'hFFFF_FFFF);
    bwr(8 * 40, (32'd2 << 4) | 32'd1);
    bwr(A_EN_HI, 32'h100);
    brd(A_VEC, d); chk(d == 64, "R3 no edge yet", d, 64);
    set_src(64'd1 << 40); set_src('0);
    brd(A_VEC, d); chk(d == 40, "R3 edge latched after fall", d, 40);
    chk(irq == 1'b1, "R3 irq from latched edge", irq, 1);
    bwr(8 * 40, (32'd2 << 4) | 32'd1);
    brd(A_VEC, d); chk(d == 64, "R4 cfg rewrite clears latch", d, 64);
    set_src(64'd1 << 40); set_src('0);
    brd(A_VEC, d); chk(d == 40, "R3 second edge", d, 40);
    bwr(A_EOI, 0);
    brd(A_VEC, d); chk(d == 64, "R4 eoi clears latch", d, 64);
    set_src(64'd1 << 40);
    bwr(A_EOI, 0);
    set_src(64'd1 << 40);
    brd(A_VEC, d); chk(d == 64, "R3 held high no retrigger", d, 64);
    set_src('0);
    bwr(A_DIS_HI, 32'h100);
    set_src(64'd1 << 40); set_src('0);
    brd(A_VEC, d); chk(d == 64, "R3 masked edge hidden", d, 64);
    bwr(A_EN_HI, 32'h100);
    brd(A_VEC, d); chk(d == 40, "R3 edge latched while masked", d, 40);
    // EOI aimed at a level source leaves edge 40 pending
    bwr(8 * 3, 32'd15 << 4); bwr(A_EN_LO, 32'h8);
    set_src(64'd1 << 3);
    brd(A_VEC, d); chk(d == 3, "R5 higher level wins", d, 3);
    bwr(A_EOI, 0);
    set_src('0);
    brd(A_VEC, d); chk(d == 40, "R4 eoi spares other sources", d, 40);

    // R6: global enable gating
    bwr(A_GEN, 0);
    chk(irq == 1'b0, "R6 gen off blocks irq", irq, 0);
    brd(A_VEC, d); chk(d == 40, "R6 vector independent of gen", d, 40);
    bwr(A_GEN, 1);
    chk(irq == 1'b1, "R6 gen on", irq, 1);

    // R9: bind table
    bwr(A_BIND, (32'd5 << 16) | 1);
    bwr(A_BIND, (32'd63 << 16) | 1);
    chk(bind_tbl == ((64'd1 << 5) | (64'd1 << 63)), "R9 bind set", bind_tbl, (64'd1 << 5) | (64'd1 << 63));
    bwr(A_BIND, (32'd5 << 16));
    chk(bind_tbl == (64'd1 << 63), "R9 bind clear", bind_tbl, 64'd1 << 63);

    // R10: strobe words read 0, enable word reads back
    brd(A_EN_LO, d);  chk(d == 0, "R10 en_lo reads 0", d, 0);
    brd(A_DIS_HI, d); chk(d == 0, "R10 dis_hi reads 0", d, 0);
    brd(A_EOI, d);    chk(d == 0, "R10 eoi reads 0", d, 0);
    brd(A_BIND, d);   chk(d == 0, "R10 bind reads 0", d, 0);
    brd(A_RST, d);    chk(d == 0, "R10 rst reads 0", d, 0);
    brd(A_GEN, d);    chk(d == 1, "R6 gen readback", d, 1);

    // R7: soft reset
    bwr(A_RST, 0);
    chk(irq == 1'b1, "R7 rst bit clear no effect", irq, 1);
    bwr(A_RST, 1);
    chk(irq == 1'b0, "R7 soft reset irq", irq, 0);
    chk(bind_tbl == '0, "R7 soft reset bind", bind_tbl, 0);
    brd(A_VEC, d);    chk(d == 64, "R7 soft reset vector", d, 64);
    brd(8 * 40, d);   chk(d == 0, "R7 soft reset cfg", d, 0);
    brd(A_GEN, d);    chk(d == 0, "R7 soft reset gen", d, 0);
    bwr(A_GEN, 1);
    set_src('1);
    chk(irq == 1'b0, "R7 masks cleared", irq, 0);

    // R11: asynchronous reset mid-run
    bwr(A_EN_LO, 32'h1); bwr(A_BIND, (32'd9 << 16) | 1);
    chk(irq == 1'b1, "R11 armed before reset", irq, 1);
    #1 rst_n = 1'b0;
    #1;
    chk(irq == 1'b0, "R11 async irq clear", irq, 0);
    chk(bind_tbl == '0, "R11 async bind clear", bind_tbl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule